// File: doc/BRIEF.md
# 8-bit ALU with Flag Register

This block is the arithmetic and logic stage of a small 8-bit RISC core. Each transfer presents an operation code, two 8-bit operands and a carry input. The block computes the result with one shared adder/subtractor, a bitwise logic unit and a shift unit. It also computes the next values of six status flags and registers both. Every operation writes only its own subset of the flags. The other flags keep the values held in the flag register, so the flags form state that persists from one operation to the next.

Operations enter on a valid/ready handshake. The registered result and the flag register leave on a second valid/ready handshake. The input is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the output slot is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the output and the flags are frozen and no new operation is accepted. A held operation can therefore never overwrite an undelivered result or its flags.

The flag vector `out_flags` is ordered from bit 5 down to bit 0 as H (half carry), S (sign), V (overflow), N (negative), Z (zero), C (carry). In a full status byte these are the six low bits. The operation codes are: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP, 5 AND, 6 OR, 7 XOR, 8 COM, 9 NEG, 10 INC, 11 DEC, 12 LSL, 13 LSR, 14 ROL, 15 ROR, 16 ASR, 17 SWAP. Codes 18 to 31 are unused.

Top module: `alu8_core`

## Requirements
- R1: ADD computes a+b and ADC computes a+b+cin, both modulo 256. Both write C (carry out of bit 7), H (carry out of bit 3), V (signed overflow), N (bit 7 of the result) and Z (result is zero).
- R2: SUB computes a-b and SBC computes a-b-cin. Both write C (borrow out of bit 7), H (borrow out of bit 3), V (signed overflow), N and Z.
- R3: CMP writes C, H, V, N and Z exactly as SUB would. Its result output is operand a, unchanged.
- R4: AND, OR and XOR write N and Z, and force V to 0. They leave C and H unchanged.
- R5: INC (a+1) and DEC (a-1) write N and Z. V is 1 only when a is 0x7F for INC, or 0x80 for DEC. C and H are unchanged.
- R6: COM gives 0xFF-a and sets C to 1 and V to 0. NEG gives 0x00-a, with C = (result not zero), H = (a[3:0] not zero) and V = (result is 0x80).
- R7: LSL and LSR shift in a 0 at the vacated end. ROL and ROR shift cin in at the vacated end. ASR keeps bit 7. All five put the bit shifted out into C, set V = N xor C, write N and Z, and leave H unchanged.
- R8: SWAP exchanges bits 7..4 with bits 3..0 and leaves all six flags unchanged.
- R9: Whenever N or V is written, S becomes N xor V, so S always equals N xor V.
- R10: An unused operation code (18..31) returns operand a and leaves all flags unchanged.
- R11: While out_valid is high and out_ready is low, the result, the flags and out_valid hold, and in_ready is low. While out_valid is low, in_ready is high.
- R12: After reset, out_valid is low, out_result is 0x00, all flags are 0 and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation presented |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | 8 | First operand (destination value) |
| in_b | input | 8 | Second operand |
| in_carry | input | 1 | Carry input for ADC, SBC, ROL and ROR |
| out_valid | output | 1 | Result and flags available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Registered result |
| out_flags | output | 6 | Flag register: H, S, V, N, Z, C from bit 5 to bit 0 |

## Verification
An operation accepted at a rising edge shows its result and its updated flags on the outputs right after that same edge, through one register stage. The bench therefore drives each vector on a falling edge, lets the next rising edge accept it, and compares at the following falling edge before it drives the next vector. This gives one vector per cycle while the output drains freely. In the stall test, the outputs are compared again on several falling edges while out_ready is low. The next vector is compared only on the falling edge after out_ready returns high. The expected flags carry over from vector to vector in the bench model, so a flag that is written when it should be kept shows up as a miscompare.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DATA_W = 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int OP_W   = 5;
  localparam int FLAG_W = 6;

  typedef enum logic [OP_W-1:0] {
    ALU_ADD  = 5'd0,  ALU_ADC = 5'd1,  ALU_SUB = 5'd2,  ALU_SBC = 5'd3,
    ALU_CMP  = 5'd4,  ALU_AND = 5'd5,  ALU_OR  = 5'd6,  ALU_XOR = 5'd7,
    ALU_COM  = 5'd8,  ALU_NEG = 5'd9,  ALU_INC = 5'd10, ALU_DEC = 5'd11,
    ALU_LSL  = 5'd12, ALU_LSR = 5'd13, ALU_ROL = 5'd14, ALU_ROR = 5'd15,
    ALU_ASR  = 5'd16, ALU_SWAP = 5'd17
  } alu_op_e;

  // Bit 5 down to bit 0: H S V N Z C
  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         is_sub,
  input  logic         use_cin,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);
  localparam int H = W / 2;

  logic [W-1:0] y_eff;
  logic         ci;
  logic         c_top;
  logic         c_half;
  logic [H-1:0] half_sum;

  // Subtraction is x + ~y + 1 (minus the carry when it is used)
  assign y_eff = is_sub ? ~y : y;
  assign ci    = is_sub ? ~(use_cin & cin) : (use_cin & cin);

  assign {c_top, sum}       = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, ci};
  assign {c_half, half_sum} = {1'b0, x[H-1:0]} + {1'b0, y_eff[H-1:0]} + {{H{1'b0}}, ci};

  // Borrow is the inverted carry
  assign c_out = is_sub ? ~c_top  : c_top;
  assign h_out = is_sub ? ~c_half : c_half;
  assign v_out = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  alu_op_e      op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      ALU_AND: res = x & y;
      ALU_OR:  res = x | y;
      ALU_XOR: res = x ^ y;
      ALU_COM: res = ~x;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  alu_op_e      op,
  input  logic [W-1:0] x,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         c_out
);
  localparam int H = W / 2;

  always_comb begin
    res   = x;
    c_out = 1'b0;
    case (op)
      ALU_LSL:  begin res = {x[W-2:0], 1'b0};     c_out = x[W-1]; end
      ALU_LSR:  begin res = {1'b0, x[W-1:1]};     c_out = x[0];   end
      ALU_ROL:  begin res = {x[W-2:0], cin};      c_out = x[W-1]; end
      ALU_ROR:  begin res = {cin, x[W-1:1]};      c_out = x[0];   end
      ALU_ASR:  begin res = {x[W-1], x[W-1:1]};   c_out = x[0];   end
      ALU_SWAP: res = {x[H-1:0], x[W-1:H]};
      default:  ;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OP_W-1:0]     in_op,
  input  logic [DATA_W-1:0]   in_a,
  input  logic [DATA_W-1:0]   in_b,
  input  logic                in_carry,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_result,
  output logic [FLAG_W-1:0]   out_flags
);
  alu_op_e             opc;
  logic [DATA_W-1:0]   ax, ay;
  logic                is_sub, use_c;
  logic [DATA_W-1:0]   sum;
  logic                c_ar, h_ar, v_ar;
  logic [DATA_W-1:0]   lres, sres;
  logic                s_co;
  logic [DATA_W-1:0]   res, fsrc;
  flags_t              nf, wm;
  logic [FLAG_W-1:0]   merged;
  logic [FLAG_W-1:0]   flag_q;
  logic                accept;

  assign opc = alu_op_e'(in_op);

  // Operand steering for the single shared adder
  always_comb begin
    ax     = in_a;
    ay     = in_b;
    is_sub = 1'b0;
    use_c  = (opc == ALU_ADC) || (opc == ALU_SBC);
    case (opc)
      ALU_SUB, ALU_SBC, ALU_CMP: is_sub = 1'b1;
      ALU_NEG: begin ax = '0; ay = in_a; is_sub = 1'b1; end
      ALU_INC: ay = DATA_W'(1);
      ALU_DEC: begin ay = DATA_W'(1); is_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(DATA_W)) u_addsub (
    .x(ax), .y(ay), .cin(in_carry), .is_sub(is_sub), .use_cin(use_c),
    .sum(sum), .c_out(c_ar), .h_out(h_ar), .v_out(v_ar)
  );

  alu8_logic #(.W(DATA_W)) u_logic (
    .op(opc), .x(in_a), .y(in_b), .res(lres)
  );

  alu8_shift #(.W(DATA_W)) u_shift (
    .op(opc), .x(in_a), .cin(in_carry), .res(sres), .c_out(s_co)
  );

  // Result select, new flag values and per-operation write mask
  always_comb begin
    res  = in_a;
    fsrc = in_a;
    nf   = '0;
    wm   = '0;
    case (opc)
      ALU_ADD, ALU_ADC, ALU_SUB, ALU_SBC, ALU_NEG, ALU_CMP: begin
        res  = (opc == ALU_CMP) ? in_a : sum;
        fsrc = sum;
        nf.c = c_ar; nf.h = h_ar; nf.v = v_ar;
        wm.c = 1'b1; wm.h = 1'b1; wm.v = 1'b1; wm.n = 1'b1; wm.z = 1'b1;
      end
      ALU_INC, ALU_DEC: begin
        res  = sum;
        fsrc = sum;
        nf.v = v_ar;
        wm.v = 1'b1; wm.n = 1'b1; wm.z = 1'b1;
      end
      ALU_AND, ALU_OR, ALU_XOR, ALU_COM: begin
        res  = lres;
        fsrc = lres;
        nf.c = 1'b1;
        wm.c = (opc == ALU_COM);
        wm.v = 1'b1; wm.n = 1'b1; wm.z = 1'b1;
      end
      ALU_LSL, ALU_LSR, ALU_ROL, ALU_ROR, ALU_ASR: begin
        res  = sres;
        fsrc = sres;
        nf.c = s_co;
        nf.v = sres[DATA_W-1] ^ s_co;
        wm.c = 1'b1; wm.v = 1'b1; wm.n = 1'b1; wm.z = 1'b1;
      end
      ALU_SWAP: begin
        res  = sres;
        fsrc = sres;
      end
      default: ;
    endcase
    nf.n = fsrc[DATA_W-1];
    nf.z = (fsrc == '0);
    nf.s = nf.n ^ nf.v;
    wm.s = wm.n | wm.v;
  end

  assign merged   = (nf & wm) | (flag_q & ~wm);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      flag_q     <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= res;
      flag_q     <= merged;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  assign out_flags = flag_q;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [OP_W-1:0]     in_op,
  input logic [DATA_W-1:0]   in_a,
  input logic                out_valid,
  input logic                out_ready,
  input logic [DATA_W-1:0]   out_result,
  input logic [FLAG_W-1:0]   out_flags
);
  logic acc;
  logic is_logic;
  assign acc      = in_valid && in_ready;
  assign is_logic = (in_op == ALU_AND) || (in_op == ALU_OR) || (in_op == ALU_XOR);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags)); // R11
  AST_READY_FREE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R11
  AST_SIGN_RULE: assert property (@(posedge clk) disable iff (rst)
    out_flags[4] == (out_flags[3] ^ out_flags[2])); // R9
  AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    acc && in_op == ALU_SWAP |=> $stable(out_flags)); // R8
  AST_LOGIC_KEEP: assert property (@(posedge clk) disable iff (rst)
    acc && is_logic |=> !out_flags[3] && out_flags[5] == $past(out_flags[5]) && out_flags[0] == $past(out_flags[0])); // R4
  AST_COM_CARRY: assert property (@(posedge clk) disable iff (rst)
    acc && in_op == ALU_COM |=> out_flags[0] && !out_flags[3]); // R6
  AST_CMP_PASS: assert property (@(posedge clk) disable iff (rst)
    acc && in_op == ALU_CMP |=> out_result == $past(in_a)); // R3
  AST_UNUSED_CODE: assert property (@(posedge clk) disable iff (rst)
    acc && in_op > ALU_SWAP |=> $stable(out_flags) && out_result == $past(in_a)); // R10
endmodule

bind alu8_core alu8_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_a(in_a), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_flags(out_flags)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_op = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic       in_carry = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [5:0] out_flags;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [5:0] mflags = '0;

  always #10 clk = ~clk;

  alu8_core dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_carry(in_carry), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 195000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, got cycle %0d exp < 195000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int o);
    case (o)
      0, 1:  return "R1";
      2, 3:  return "R2";
      4:     return "R3";
      5, 6, 7: return "R4";
      10, 11:  return "R5";
      8, 9:  return "R6";
      12, 13, 14, 15, 16: return "R7";
      17:    return "R8";
      default: return "R10";
    endcase
  endfunction

  // Arithmetic reference model, flags bit 5..0 = H S V N Z C
  task automatic ref_op(input int o, input int x, input int y, input int c,
                        input logic [5:0] fi, output int r, output logic [5:0] fo);
    int t, zr, cc;
    bit wc, wh, wv, wnz, vsh;
    bit cf, hf, vf, nf;
    fo = fi; r = x; zr = x;
    wc = 0; wh = 0; wv = 0; wnz = 0; vsh = 0;
    cf = 0; hf = 0; vf = 0;
    case (o)
      0, 1: begin
        cc = (o == 1) ? c : 0;
        t = x + y + cc; r = t & 255; zr = r;
        cf = t > 255; hf = ((x & 15) + (y & 15) + cc) > 15;
        vf = ((x ^ r) & (y ^ r) & 128) != 0;
        wc = 1; wh = 1; wv = 1; wnz = 1;
      end
      2, 3, 4: begin
        cc = (o == 3) ? c : 0;
        t = x - y - cc; zr = t & 255; r = (o == 4) ? x : zr;
        cf = t < 0; hf = ((x & 15) - (y & 15) - cc) < 0;
        vf = ((x ^ y) & (x ^ zr) & 128) != 0;
        wc = 1; wh = 1; wv = 1; wnz = 1;
      end
      5: begin r = x & y; zr = r; wv = 1; wnz = 1; end
      6: begin r = x | y; zr = r; wv = 1; wnz = 1; end
      7: begin r = x ^ y; zr = r; wv = 1; wnz = 1; end
      8: begin r = 255 - x; zr = r; cf = 1; wc = 1; wv = 1; wnz = 1; end
      9: begin
        r = (256 - x) & 255; zr = r;
        cf = r != 0; hf = (x & 15) != 0; vf = r == 128;
        wc = 1; wh = 1; wv = 1; wnz = 1;
      end
      10: begin r = (x + 1) & 255; zr = r; vf = x == 127; wv = 1; wnz = 1; end
      11: begin r = (x + 255) & 255; zr = r; vf = x == 128; wv = 1; wnz = 1; end
      12: begin r = (x * 2) & 255; cf = x >= 128; vsh = 1; end
      13: begin r = x / 2; cf = (x & 1) != 0; vsh = 1; end
      14: begin r = (x * 2 + c) & 255; cf = x >= 128; vsh = 1; end
      15: begin r = x / 2 + c * 128; cf = (x & 1) != 0; vsh = 1; end
      16: begin r = x / 2 + (x & 128); cf = (x & 1) != 0; vsh = 1; end
      17: begin r = (x & 15) * 16 + x / 16; zr = r; end
      default: ;
    endcase
    if (vsh) begin zr = r; wc = 1; wv = 1; wnz = 1; end
    nf = zr >= 128;
    if (vsh) vf = nf ^ cf;
    if (wc) fo[0] = cf;
    if (wh) fo[5] = hf;
    if (wv) fo[3] = vf;
    if (wnz) begin fo[2] = nf; fo[1] = (zr == 0); end
    if (wv || wnz) fo[4] = fo[2] ^ fo[3];
  endtask

  // Drive on a falling edge, accepted at the next rising edge, compared on the following falling edge
  task automatic step(input int o, input int x, input int y, input int c);
    int er;
    logic [5:0] ef;
    in_op = 5'(o); in_a = 8'(x); in_b = 8'(y); in_carry = c[0]; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_op(o, x, y, c, mflags, er, ef);
    mflags = ef;
    chk(out_valid == 1'b1, tag_of(o), "out_valid", int'(out_valid), 1);
    chk(out_result == 8'(er), tag_of(o), "result", int'(out_result), er);
    chk(out_flags == ef, tag_of(o), "flags", int'(out_flags), int'(ef));
    chk(out_flags[4] == (out_flags[3] ^ out_flags[2]), "R9", "sign", int'(out_flags[4]),
        int'(out_flags[3] ^ out_flags[2]));
  endtask

  function automatic int bval(input int k, input int x);
    case (k)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h0F;  3: return 8'h10;
      4: return 8'h7F;  5: return 8'h80;  6: return 8'hF0;  7: return 8'hFF;
      default: return (x * 37 + 11) & 255;
    endcase
  endfunction

  initial begin
    int er;
    logic [5:0] ef;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(out_valid == 1'b0, "R12", "out_valid", int'(out_valid), 0);
    chk(out_result == 8'h00, "R12", "result", int'(out_result), 0);
    chk(out_flags == 6'h00, "R12", "flags", int'(out_flags), 0);
    chk(in_ready == 1'b1, "R12", "in_ready", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);

    // R1..R8: near-exhaustive sweep, flags chained across vectors
    for (int o = 0; o < 18; o++)
      for (int x = 0; x < 256; x++)
        for (int k = 0; k < 9; k++)
          for (int ci = 0; ci < 2; ci++)
            step(o, x, bval(k, x), ci);

    // R10: unused codes
    for (int o = 18; o < 32; o++) begin
      step(9, 8'h40, 0, 0);
      step(o, 8'h5A, 8'hC3, 1);
      step(o, 8'h00, 8'hFF, 0);
    end

    // R11: back-pressure
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11", "drained", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R11", "in_ready idle", int'(in_ready), 1);
    out_ready = 1'b0;
    in_op = 5'd0; in_a = 8'h7F; in_b = 8'h01; in_carry = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_op(0, 8'h7F, 8'h01, 0, mflags, er, ef);
    mflags = ef;
    chk(out_result == 8'(er), "R11", "first result", int'(out_result), er);
    chk(in_ready == 1'b0, "R11", "in_ready stalled", int'(in_ready), 0);
    in_op = 5'd12; in_a = 8'h81; in_b = 8'h00;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R11", "valid held", int'(out_valid), 1);
      chk(out_result == 8'(er), "R11", "result held", int'(out_result), er);
      chk(out_flags == ef, "R11", "flags held", int'(out_flags), int'(ef));
      chk(in_ready == 1'b0, "R11", "in_ready held", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_op(12, 8'h81, 8'h00, 0, mflags, er, ef);
    mflags = ef;
    chk(out_result == 8'(er), "R11", "second result", int'(out_result), er);
    chk(out_flags == ef, "R11", "second flags", int'(out_flags), int'(ef));
    in_valid = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule